// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block counts clock cycles while it is running and raises a reset request when the count reaches a programmable limit. Software keeps the system alive by writing to a restart register before the limit is reached. Any write to that register clears the count, whatever data it carries.

Starting or stopping the timer is guarded. A write to the configuration register changes the running state only if the key register was loaded just before with the magic value for that direction. Start and stop each have their own value. Every configuration write uses up the armed key, whether or not the write takes effect. The running state can be read back from the configuration register.

The register port is a plain strobe interface with a two-bit word address. Writes take effect on the clock edge. Reads are combinational.

Top module: `keyed_wdog`

## Requirements
- R1: A synchronous reset leaves the timer stopped, the count at zero, no key armed and `reset_req` low.
- R2: Writing 0x2 selects the restart register; a write there with any data clears the count to zero.
- R3: Writing 16'hEABE to the key register (address 0x0), followed by a configuration write (address 0x1) with bit 0 set, starts the timer. Starting always begins from a count of zero, even if the timer was already running.
- R4: Writing 16'hDEAD to the key register, followed by a configuration write with bit 1 set, stops the timer and clears the count. A stopped timer never raises `reset_req`.
- R5: A configuration write is ignored if the key register does not hold the matching armed value. This covers no key, a wrong value, and the key of the opposite direction.
- R6: Each configuration write consumes the armed key, whether it matched or not. A later configuration write needs a fresh key.
- R7: While the timer runs, `reset_req` goes high for exactly one cycle on the TIMEOUT-th clock edge after the start or the last clear. The count then wraps to zero, so pulses repeat every TIMEOUT cycles.
- R8: A read with `rd_en` at address 0x1 returns the running state in bit 0 and zeros in all other bits. Reads at any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register word address: 0 key, 1 configuration, 2 restart |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench measures the exact cycle distance from a start or a restart to the pulse. A design that compared against the wrong terminal value would fire one cycle early or late. A design that failed to clear the count on restart would fire too soon. The bench also checks that the pulse repeats one period later, which exposes a counter that sticks or fails to wrap.

Key handling is attacked with:
- a missing key;
- a wrong key;
- the opposite direction's key;
- a key spent by an empty configuration write.

A design that left keys armed, or accepted either key for both directions, would change state where it must not. A design whose stop path leaked would go on raising reset requests after it was stopped.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int TIMEOUT = 1000,
  parameter int DW = 16,
  parameter logic [15:0] KEY_ON = 16'hEABE,
  parameter logic [15:0] KEY_OFF = 16'hDEAD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          reset_req
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
  localparam logic [1:0] A_KEY = 2'd0, A_CFG = 2'd1, A_KICK = 2'd2;

  logic          en_q, arm_on_q, arm_off_q;
  logic [CW-1:0] cnt_q;

  wire wr_key  = wr_en && addr == A_KEY;
  wire wr_cfg  = wr_en && addr == A_CFG;
  wire wr_kick = wr_en && addr == A_KICK;
  wire do_off  = wr_cfg && arm_off_q && wdata[1];
  wire do_on   = wr_cfg && arm_on_q && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      arm_on_q  <= 1'b0;
      arm_off_q <= 1'b0;
      cnt_q     <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= 1'b0;
      if (wr_key) begin
        arm_on_q  <= wdata[15:0] == KEY_ON;
        arm_off_q <= wdata[15:0] == KEY_OFF;
      end else if (wr_cfg) begin
        arm_on_q  <= 1'b0;
        arm_off_q <= 1'b0;
      end
      if (do_off) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else if (do_on) begin
        en_q  <= 1'b1;
        cnt_q <= '0;
      end else if (wr_kick) begin
        cnt_q <= '0;
      end else if (en_q) begin
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          reset_req <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rdata = (rd_en && addr == A_CFG) ? DW'(en_q) : '0;
endmodule

module keyed_wdog_chk #(parameter int TIMEOUT = 1000, parameter int CW = 1) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic          en_q,
  input logic [CW-1:0] cnt_q,
  input logic          reset_req
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!en_q && cnt_q == '0 && !reset_req));
  // R2
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd2) |=> cnt_q == '0);
  // R3
  start_by_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> ($past(wr_en) && $past(addr) == 2'd1 && cnt_q == '0));
  // R4
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(en_q));
  // R7
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);
  // R7
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < TIMEOUT);
endmodule

bind keyed_wdog keyed_wdog_chk #(.TIMEOUT(TIMEOUT), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .en_q(en_q), .cnt_q(cnt_q), .reset_req(reset_req));

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  localparam int TO = 20;
  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic reset_req;
  int errors = 0, checks = 0;
  bit done = 0;

  keyed_wdog #(.TIMEOUT(TO)) dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .reset_req(reset_req));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_en = 1; addr = a; #1; v = int'(rdata); rd_en = 0; addr = 0;
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    for (int i = 1; i <= 4 * TO; i++) begin
      @(negedge clk);
      if (reset_req) begin n = i; break; end
    end
  endtask

  task automatic quiet(input int cyc, input string tag);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (reset_req) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  task automatic start();
    wr(2'd0, 16'hEABE); wr(2'd1, 16'h0001);
  endtask

  task automatic stop();
    wr(2'd0, 16'hDEAD); wr(2'd1, 16'h0002);
  endtask

  task automatic t_reset();
    int v;
    rd(2'd1, v); check(v == 0, "R1 stopped after reset", v, 0);
    check(reset_req == 0, "R1 reset_req low", reset_req, 0);
    wr(2'd1, 16'h0001); rd(2'd1, v);
    check(v == 0, "R1 no key armed after reset", v, 0);
    quiet(2 * TO, "R1 no pulse after reset");
  endtask

  task automatic t_start_period();
    int n, v;
    start(); rd(2'd1, v); check(v == 1, "R3 start readback", v, 1);
    rd(2'd0, v); check(v == 0, "R8 other address reads zero", v, 0);
    wait_pulse(n); check(n == TO, "R7 first timeout distance", n, TO);
    @(negedge clk); check(reset_req == 0, "R7 pulse one cycle", reset_req, 0);
    wait_pulse(n); check(n == TO - 1, "R7 wrap period", n + 1, TO);
    stop();
  endtask

  task automatic t_kick();
    int n;
    start();
    repeat (15) @(negedge clk);
    wr(2'd2, 16'h5A5A);
    wait_pulse(n); check(n == TO, "R2 restart clears count", n, TO);
    repeat (10) @(negedge clk);
    wr(2'd2, 16'h0000);
    wait_pulse(n); check(n == TO, "R2 restart with zero data", n, TO);
    stop();
  endtask

  task automatic t_restart_on_enable();
    int n;
    start();
    repeat (12) @(negedge clk);
    start();
    wait_pulse(n); check(n == TO, "R3 re-enable starts from zero", n, TO);
    stop();
  endtask

  task automatic t_stop();
    int v;
    start(); repeat (5) @(negedge clk);
    stop(); rd(2'd1, v); check(v == 0, "R4 stop readback", v, 0);
    quiet(3 * TO, "R4 stopped raises no request");
  endtask

  task automatic t_bad_keys();
    int v;
    wr(2'd0, 16'h1234); wr(2'd1, 16'h0001); rd(2'd1, v);
    check(v == 0, "R5 wrong key ignored", v, 0);
    wr(2'd0, 16'hDEAD); wr(2'd1, 16'h0001); rd(2'd1, v);
    check(v == 0, "R5 stop key cannot start", v, 0);
    start();
    wr(2'd0, 16'hEABE); wr(2'd1, 16'h0002); rd(2'd1, v);
    check(v == 1, "R5 start key cannot stop", v, 1);
    wr(2'd1, 16'h0002); rd(2'd1, v);
    check(v == 1, "R5 stop without key ignored", v, 1);
    stop();
  endtask

  task automatic t_consume();
    int v;
    wr(2'd0, 16'hEABE); wr(2'd1, 16'h0000); wr(2'd1, 16'h0001); rd(2'd1, v);
    check(v == 0, "R6 key consumed by empty write", v, 0);
    start();
    wr(2'd0, 16'hDEAD); wr(2'd1, 16'h0001); wr(2'd1, 16'h0002); rd(2'd1, v);
    check(v == 1, "R6 stop key consumed by mismatch", v, 1);
    stop();
  endtask

  task automatic t_reset_running();
    int v;
    start(); repeat (7) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    rd(2'd1, v); check(v == 0, "R1 reset stops running timer", v, 0);
    quiet(2 * TO, "R1 no pulse after mid-run reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_start_period();
    t_kick();
    t_restart_on_enable();
    t_stop();
    t_bad_keys();
    t_consume();
    t_reset_running();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule